// File: doc/BRIEF.md
# System-Control Exception Unit

This block holds the system-control registers of a 32-bit MIPS-I style core: a status word, a cause word, an exception-return address (EPC) and a read-only revision identifier. It also carries out exception entry. A synchronous exception request brings a 5-bit exception code, a 2-bit delay-slot flag and the PC of the instruction that faulted. An external interrupt is raised internally when the interrupt status and mask words overlap and the status word allows it.

On entry the unit records the cause and the return address and pushes the three-level mode/interrupt-enable stack held in the low six status bits. It then presents the vector address on `redirect_pc` together with a one-cycle `exc_taken` strobe. A return strobe pops that stack. The core reads and writes the registers through a 5-bit register-number port.

Control is a two-state machine. `ST_RUN` is the normal state. The transition `RUN->ENTER` fires on a synchronous request, or on a qualified interrupt when no request is present. `ST_ENTER` lasts exactly one cycle, drives the strobe, and always takes the transition `ENTER->RUN`.

Top module: `sysctl_exc_unit`

## Requirements
- R1: After reset `redirect_pc` is 0xBFC00000, `exc_taken` is 0, status reads 0x10600000, the revision register reads 0x00000002, and cause and EPC read 0.
- R2: On entry the cause word becomes (flags << 30) | (old cause & 0x700) | code bits. For a synchronous exception the code bits are `exc_code` placed at bits 6:2. Bits 9:8 and 10 of the old cause survive.
- R3: On a synchronous entry EPC receives `fault_pc` - 4 when `bd_flags` is nonzero, and `fault_pc` otherwise.
- R4: The vector on `redirect_pc` is 0xBFC00180 when status bit 22 is set at entry, and 0x80000080 when it is clear.
- R5: On entry status bits 5:0 become {old bits 3:0, 2'b00}. Bits 31:6 are unchanged.
- R6: With no synchronous request, an interrupt entry happens when (irq_stat & irq_mask) is nonzero and status bits 10 and 0 are both set. It ORs 0x400 into the cause (ExcCode 0), clears the flags at bits 31:30 and stores `fault_pc` in EPC.
- R7: A `rfe` pulse copies status bits 5:2 into bits 3:0 and leaves bits 5:4 unchanged. A status write in the same cycle takes precedence over it.
- R8: A write to register 13 (cause) changes only bits 9:8.
- R9: When a synchronous request and a qualified interrupt coincide, the synchronous exception is taken, with its own code and flags.
- R10: `exc_taken` rises in the cycle after the accepted request and lasts exactly one cycle, with `redirect_pc` already holding the vector. Requests and interrupts present during that strobe cycle are ignored.
- R11: Register map: 12 is status (read/write), 13 is cause, 14 is EPC (read/write), 15 is the revision ID (read-only). Any other number reads 0. `reg_rdata` follows `reg_addr` in the same cycle.
- R12: In a cycle where an entry is accepted, register writes and `rfe` have no effect on status, cause or EPC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Exception code of the request |
| bd_flags | input | 2 | Delay-slot flags; bit 1 = branch delay |
| fault_pc | input | 32 | PC of the current/faulting instruction |
| rfe | input | 1 | Return-from-exception stack pop |
| irq_stat | input | IRQ_W | External interrupt status word |
| irq_mask | input | IRQ_W | External interrupt mask word |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 5 | Register number for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| exc_taken | output | 1 | One-cycle exception-entry strobe |
| redirect_pc | output | 32 | Next PC: reset address or exception vector |

## Verification
Three cases can fall in the same cycle in `ST_RUN`: a synchronous request and a qualified interrupt, a register write and an entry, and a return pulse and an entry. Directed cycles set up the status word so that the interrupt qualifies. They then raise `exc_req` together with the interrupt, or together with writes and `rfe`. The recorded code, flags, EPC and status are read back in the following cycles. Random traffic keeps these overlaps frequent, and a bench model applies the priority rules to judge every read.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int XLEN = 32;
    localparam int RA_W = 5;

    localparam logic [RA_W-1:0] RA_SR    = 5'd12;
    localparam logic [RA_W-1:0] RA_CAUSE = 5'd13;
    localparam logic [RA_W-1:0] RA_EPC   = 5'd14;
    localparam logic [RA_W-1:0] RA_PRID  = 5'd15;

    localparam logic [XLEN-1:0] RST_PC   = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] RST_SR   = 32'h1060_0000;
    localparam logic [XLEN-1:0] VEC_BOOT = 32'hBFC0_0180;
    localparam logic [XLEN-1:0] VEC_RAM  = 32'h8000_0080;
    localparam logic [XLEN-1:0] IRQ_CODE = 32'h0000_0400;
    localparam logic [XLEN-1:0] KEEP_MSK = 32'h0000_0700;

    localparam int SR_BEV  = 22;
    localparam int SR_IMHW = 10;
    localparam int SR_IEC  = 0;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_ENTER = 1'b1
    } exc_state_e;

    typedef struct packed {
        logic [1:0]      flags;
        logic [XLEN-1:0] code_or;
        logic [XLEN-1:0] epc;
    } entry_t;

endpackage

// File: rtl/exc_ctrl_fsm.sv
module exc_ctrl_fsm
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_req,
    input  logic [4:0]      exc_code,
    input  logic [1:0]      bd_flags,
    input  logic [XLEN-1:0] fault_pc,
    input  logic            irq_hit,
    input  logic            sr_bev,
    input  logic            sr_imhw,
    input  logic            sr_iec,
    output logic            entry_fire,
    output entry_t          entry,
    output logic            exc_taken,
    output logic [XLEN-1:0] redirect_pc
);

    exc_state_e      state_q, state_d;
    logic            take_sync, take_irq, irq_ok;
    logic [XLEN-1:0] redirect_q;

    assign irq_ok = irq_hit && sr_imhw && sr_iec;

    // next-state and acceptance
    always_comb begin
        state_d   = state_q;
        take_sync = 1'b0;
        take_irq  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (exc_req) begin
                    take_sync = 1'b1;
                    state_d   = ST_ENTER;
                end else if (irq_ok) begin
                    take_irq  = 1'b1;
                    state_d   = ST_ENTER;
                end
            end
            ST_ENTER: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // vector register
    always_ff @(posedge clk) begin
        if (!rst_n)          redirect_q <= RST_PC;
        else if (entry_fire) redirect_q <= sr_bev ? VEC_BOOT : VEC_RAM;
    end

    // outputs
    always_comb begin
        entry_fire    = take_sync || take_irq;
        entry.flags   = take_sync ? bd_flags : 2'b00;
        entry.code_or = take_sync ? {25'd0, exc_code, 2'b00} : IRQ_CODE;
        entry.epc     = (take_sync && (bd_flags != 2'b00)) ? (fault_pc - 32'd4) : fault_pc;
        exc_taken     = (state_q == ST_ENTER);
        redirect_pc   = redirect_q;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> !exc_taken); // R10
    AST_FIRE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_fire |=> exc_taken); // R10
    AST_NO_FIRE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> !entry_fire); // R10
    AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (redirect_pc == VEC_BOOT || redirect_pc == VEC_RAM)); // R4

endmodule

// File: rtl/status_stack.sv
module status_stack
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            entry_fire,
    input  logic            rfe,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] sr
);

    logic [XLEN-1:0] sr_q, sr_d;

    always_comb begin
        sr_d = sr_q;
        if (entry_fire)
            sr_d = {sr_q[XLEN-1:6], sr_q[3:0], 2'b00};
        else if (wr_en)
            sr_d = wdata;
        else if (rfe)
            sr_d = {sr_q[XLEN-1:4], sr_q[5:2]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= RST_SR;
        else        sr_q <= sr_d;
    end

    assign sr = sr_q;

    AST_PUSH_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        entry_fire |=> sr_q[5:0] == {$past(sr_q[3:0]), 2'b00}); // R5
    AST_PUSH_KEEP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        entry_fire |=> sr_q[XLEN-1:6] == $past(sr_q[XLEN-1:6])); // R5
    AST_POP_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && !wr_en && !entry_fire) |=>
            (sr_q[3:0] == $past(sr_q[5:2]) && sr_q[5:4] == $past(sr_q[5:4]))); // R7

endmodule

// File: rtl/cause_epc_file.sv
module cause_epc_file
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            entry_fire,
    input  entry_t          entry,
    input  logic            cause_we,
    input  logic [1:0]      cause_sw,
    input  logic            epc_we,
    input  logic [XLEN-1:0] epc_wdata,
    output logic [XLEN-1:0] cause,
    output logic [XLEN-1:0] epc
);

    logic [XLEN-1:0] cause_q, cause_d, epc_q, epc_d;

    always_comb begin
        cause_d = cause_q;
        epc_d   = epc_q;
        if (entry_fire) begin
            cause_d = {entry.flags, {(XLEN-2){1'b0}}} | (cause_q & KEEP_MSK) | entry.code_or;
            epc_d   = entry.epc;
        end else begin
            if (cause_we) cause_d = {cause_q[XLEN-1:10], cause_sw, cause_q[7:0]};
            if (epc_we)   epc_d   = epc_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else begin
            cause_q <= cause_d;
            epc_q   <= epc_d;
        end
    end

    assign cause = cause_q;
    assign epc   = epc_q;

    AST_CAUSE_WMASK: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_we && !entry_fire) |=>
            (cause_q[XLEN-1:10] == $past(cause_q[XLEN-1:10]) && cause_q[7:0] == $past(cause_q[7:0]))); // R8
    AST_CAUSE_KEEP_SW: assert property (@(posedge clk) disable iff (!rst_n)
        entry_fire |=> cause_q[9:8] == $past(cause_q[9:8])); // R2
    AST_CAUSE_KEEP_IP: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_fire && $past(cause_q[10])) |=> cause_q[10]); // R2

endmodule

// File: rtl/sysctl_exc_unit.sv
module sysctl_exc_unit
    import sysctl_pkg::*;
#(
    parameter int          IRQ_W    = 16,
    parameter logic [31:0] PRID_VAL = 32'h0000_0002
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic [4:0]       exc_code,
    input  logic [1:0]       bd_flags,
    input  logic [31:0]      fault_pc,
    input  logic             rfe,
    input  logic [IRQ_W-1:0] irq_stat,
    input  logic [IRQ_W-1:0] irq_mask,
    input  logic             reg_we,
    input  logic [4:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             exc_taken,
    output logic [31:0]      redirect_pc
);

    logic            entry_fire;
    entry_t          entry;
    logic [XLEN-1:0] sr, cause, epc;
    logic            irq_hit;
    logic            wr_sr, wr_cause, wr_epc;

    assign irq_hit  = |(irq_stat & irq_mask);
    assign wr_sr    = reg_we && (reg_addr == RA_SR);
    assign wr_cause = reg_we && (reg_addr == RA_CAUSE);
    assign wr_epc   = reg_we && (reg_addr == RA_EPC);

    exc_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .exc_req     (exc_req),
        .exc_code    (exc_code),
        .bd_flags    (bd_flags),
        .fault_pc    (fault_pc),
        .irq_hit     (irq_hit),
        .sr_bev      (sr[SR_BEV]),
        .sr_imhw     (sr[SR_IMHW]),
        .sr_iec      (sr[SR_IEC]),
        .entry_fire  (entry_fire),
        .entry       (entry),
        .exc_taken   (exc_taken),
        .redirect_pc (redirect_pc)
    );

    status_stack u_sr (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry_fire (entry_fire),
        .rfe        (rfe),
        .wr_en      (wr_sr),
        .wdata      (reg_wdata),
        .sr         (sr)
    );

    cause_epc_file u_ce (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry_fire (entry_fire),
        .entry      (entry),
        .cause_we   (wr_cause),
        .cause_sw   (reg_wdata[9:8]),
        .epc_we     (wr_epc),
        .epc_wdata  (reg_wdata),
        .cause      (cause),
        .epc        (epc)
    );

    always_comb begin
        unique case (reg_addr)
            RA_SR:    reg_rdata = sr;
            RA_CAUSE: reg_rdata = cause;
            RA_EPC:   reg_rdata = epc;
            RA_PRID:  reg_rdata = PRID_VAL;
            default:  reg_rdata = '0;
        endcase
    end

    AST_SYNC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(exc_taken) && $past(exc_req)) |-> cause[6:2] == $past(exc_code)); // R9
    AST_IRQ_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(exc_taken) && !$past(exc_req)) |->
            (cause[10] && cause[31:30] == 2'b00 && $past(sr[SR_IEC] && sr[SR_IMHW] && irq_hit))); // R6
    AST_EPC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(exc_taken) && $past(exc_req) && $past(bd_flags) != 2'b00) |->
            epc == $past(fault_pc) - 32'd4); // R3

endmodule

// File: tb/sysctl_exc_unit_bench.sv
module sysctl_exc_unit_bench;

    localparam int IRQ_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             exc_req = 1'b0;
    logic [4:0]       exc_code = '0;
    logic [1:0]       bd_flags = '0;
    logic [31:0]      fault_pc = '0;
    logic             rfe = 1'b0;
    logic [IRQ_W-1:0] irq_stat = '0;
    logic [IRQ_W-1:0] irq_mask = '0;
    logic             reg_we = 1'b0;
    logic [4:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             exc_taken;
    logic [31:0]      redirect_pc;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] m_sr, m_cause, m_epc, m_pc;
    logic        m_enter;

    always #5 clk = ~clk;

    sysctl_exc_unit #(.IRQ_W(IRQ_W)) u_sysctl_exc_unit (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .bd_flags(bd_flags), .fault_pc(fault_pc), .rfe(rfe), .irq_stat(irq_stat),
        .irq_mask(irq_mask), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_taken(exc_taken),
        .redirect_pc(redirect_pc)
    );

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'd12:   return m_sr;
            5'd13:   return m_cause;
            5'd14:   return m_epc;
            5'd15:   return 32'h2;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string addr_req(input logic [4:0] a);
        case (a)
            5'd12:   return "R5";
            5'd13:   return "R2";
            5'd14:   return "R3";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic irq_ok, sync, fire;
        logic [1:0]  fl;
        logic [31:0] cb;
        irq_ok = (|(irq_stat & irq_mask)) && m_sr[10] && m_sr[0];
        sync   = !m_enter && exc_req;
        fire   = !m_enter && (exc_req || irq_ok);
        if (fire) begin
            fl      = sync ? bd_flags : 2'b00;
            cb      = sync ? {25'd0, exc_code, 2'b00} : 32'h400;
            m_cause = ({30'd0, fl} << 30) | (m_cause & 32'h700) | cb;
            m_epc   = (sync && fl != 2'b00) ? fault_pc - 32'd4 : fault_pc;
            m_pc    = m_sr[22] ? 32'hBFC0_0180 : 32'h8000_0080;
            m_sr    = {m_sr[31:6], m_sr[3:0], 2'b00};
        end else begin
            if (reg_we && reg_addr == 5'd12) m_sr = reg_wdata;
            else if (rfe) m_sr = {m_sr[31:4], m_sr[5:2]};
            if (reg_we && reg_addr == 5'd13) m_cause = {m_cause[31:10], reg_wdata[9:8], m_cause[7:0]};
            if (reg_we && reg_addr == 5'd14) m_epc = reg_wdata;
        end
        m_enter = fire;
    endtask

    // inputs are already set just after a negedge
    task automatic cycle(input string why);
        string rq;
        #1;
        check((why == "") ? "R10" : why, {31'd0, exc_taken}, {31'd0, m_enter});
        check((why == "") ? "R4" : why, redirect_pc, m_pc);
        rq = (why == "") ? addr_req(reg_addr) : why;
        check(rq, reg_rdata, m_read(reg_addr));
        model_step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        exc_req = 0; rfe = 0; reg_we = 0; irq_stat = '0; irq_mask = '0;
        bd_flags = 0; exc_code = 0;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd4242);
        m_sr = 32'h1060_0000; m_cause = 0; m_epc = 0; m_pc = 32'hBFC0_0000; m_enter = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, every register
        for (int a = 12; a < 17; a++) begin
            reg_addr = a[4:0];
            cycle("R1");
        end

        // set BEV, IM bit 10, stack bits 3:0 = 1111
        reg_we = 1; reg_addr = 5'd12; reg_wdata = 32'h0040_040F;
        cycle("R11");
        reg_we = 0; reg_addr = 5'd12;
        cycle("R11");

        // R9: sync request with qualified interrupt in the same cycle, branch delay
        exc_req = 1; exc_code = 5'd4; bd_flags = 2'b10; fault_pc = 32'h0000_1000;
        irq_stat = 16'h0001; irq_mask = 16'h0001; reg_addr = 5'd13;
        cycle("R9");
        // R10: strobe cycle, new request ignored
        exc_req = 1; exc_code = 5'd9; bd_flags = 2'b00; fault_pc = 32'h0000_3000;
        cycle("R10");
        idle_inputs();
        reg_addr = 5'd14; cycle("R3");
        reg_addr = 5'd12; cycle("R5");

        // R7: return pops the stack
        rfe = 1; cycle("R7");
        rfe = 0; cycle("R7");

        // R8: cause write touches only bits 9:8
        reg_we = 1; reg_addr = 5'd13; reg_wdata = 32'hFFFF_FFFF;
        cycle("R8");
        reg_we = 0; cycle("R8");

        // R6: interrupt only, BEV clear
        reg_we = 1; reg_addr = 5'd12; reg_wdata = 32'h0000_0401;
        cycle("R6");
        reg_we = 0; reg_addr = 5'd13;
        irq_stat = 16'h8000; irq_mask = 16'h8000; bd_flags = 2'b11; fault_pc = 32'h0000_2000;
        cycle("R6");
        idle_inputs();
        cycle("R6");
        reg_addr = 5'd14; cycle("R6");
        reg_addr = 5'd12; cycle("R6");

        // R12: entry with concurrent EPC write and rfe
        exc_req = 1; exc_code = 5'd12; bd_flags = 2'b01; fault_pc = 32'h0000_4000;
        reg_we = 1; reg_addr = 5'd14; reg_wdata = 32'hDEAD_BEEF; rfe = 1;
        cycle("R12");
        idle_inputs();
        reg_addr = 5'd14; cycle("R12");
        reg_addr = 5'd12; cycle("R12");
        reg_addr = 5'd15; reg_we = 1; reg_wdata = 32'h1234_5678; cycle("R11");
        reg_we = 0; cycle("R11");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            exc_req  = ($urandom % 8) == 0;
            exc_code = 5'($urandom);
            bd_flags = 2'($urandom);
            fault_pc = {$urandom} & 32'hFFFF_FFFC;
            rfe      = ($urandom % 10) == 0;
            irq_stat = ($urandom % 3 == 0) ? IRQ_W'($urandom) : '0;
            irq_mask = IRQ_W'($urandom);
            reg_we   = ($urandom % 4) == 0;
            reg_addr = ($urandom % 5 == 0) ? 5'($urandom) : 5'(12 + ($urandom % 4));
            reg_wdata = $urandom;
            cycle("");
        end

        idle_inputs();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule